// File: doc/BRIEF.md
# Area chip-select generator

This block splits a 24-bit bus address space into eight equal areas and gives each area an active-low select strobe. The strobe of an area falls while a bus access whose address lies in that area goes to external space. The highest area also holds an on-chip RAM window and an internal register window. Accesses to either of those stay inside the chip and raise no strobe. A RAM-enable control bit moves the RAM window out to external space. When it does, accesses there select the highest area like the rest of that area.

Each strobe pin has a direction bit. The pin drives the strobe only while that bit is 1, and otherwise the pin floats. The reset values of the direction bits follow the boot mode. When the on-chip ROM is off, the area 0 pin comes out of reset as an output so that the first fetch can reach external memory. When the on-chip ROM is on, every pin comes out of reset as an input. Four of the areas (2 to 5) can each be marked as DRAM space. The strobe pin of a marked area then carries a row-address strobe, and a per-pin function flag reports this. A small write port loads the direction bits, the RAM-enable bit and the DRAM mask.

Top module: `area_cs_gen`

## Requirements
- R1: Of the eight strobes in `cs_n`, at most one is low in any cycle.
- R2: The area index is `acc_addr[23:21]`. If `acc_valid` is high at a clock edge and the address is external, `cs_n[area]` is low in the following cycle. Every strobe is high in the cycle after an edge at which `acc_valid` was low, so an access held for several cycles keeps its strobe low throughout.
- R3: An access inside the register window (`REG_LO`..`REG_HI`, inside area 7) never lowers any strobe.
- R4: With RAM enable at 1, an access inside the RAM window (`RAM_LO`..`RAM_HI`) lowers no strobe. With RAM enable at 0, such an access lowers `cs_n[7]`. Area 7 addresses outside both windows always lower `cs_n[7]`.
- R5: `cs_oe[k]` equals direction bit k. A write with `cfg_addr` = 0 loads all eight direction bits from `cfg_wdata[7:0]` (bit k for area k), and the new value appears in the cycle after the write.
- R6: While `rst_n` is low at a clock edge, `cs_n` becomes 8'hFF, RAM enable becomes 1 and the DRAM mask becomes 0. The direction bits become 8'h01 if `boot_int_rom` is 0 and 8'h00 if it is 1.
- R7: A write with `cfg_addr` = 1 loads RAM enable from `cfg_wdata[0]`. A write with `cfg_addr` = 2 loads the DRAM mask from `cfg_wdata[3:0]`, where bit j marks area j+2. `ras_mode[k]` is high exactly for the marked areas, and bits 0, 1, 6 and 7 are always low.
- R8: A write with `cfg_addr` = 3 changes none of the direction bits, the RAM enable or the DRAM mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_int_rom | input | 1 | Boot mode: 1 when the on-chip ROM is enabled; sampled during reset |
| acc_valid | input | 1 | Address strobe: a bus access is in progress |
| acc_addr | input | 24 | Bus address of the access |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cs_n | output | 8 | Registered active-low area strobes |
| cs_oe | output | 8 | Per-pin output enable (direction bits) |
| ras_mode | output | 8 | Per-pin flag: the strobe serves as a row-address strobe |

## Verification
The assertions assume that `acc_addr` is stable and known whenever `acc_valid` is high. They also assume that configuration writes and bus accesses may share a cycle, and that the windows sit inside area 7 without overlapping. The elaboration checks in the top module enforce the window layout. The stimulus changes every input only on the falling edge. It biases the random addresses toward the window edges, the area boundaries and the gap between the two windows, and mixes random writes to all four register selects into ongoing traffic.

// File: rtl/area_cs_pkg.sv
`timescale 1ns/1ps
package area_cs_pkg;
   localparam int CFG_SEL_W = 2;

   typedef enum logic [CFG_SEL_W-1:0] {
      SEL_DIR   = 2'd0,
      SEL_RAMEN = 2'd1,
      SEL_DRAM  = 2'd2,
      SEL_NONE  = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/area_cs_regs.sv
`timescale 1ns/1ps
module area_cs_regs
   import area_cs_pkg::*;
#(
   parameter int N_AREA   = 8,
   parameter int DATA_W   = 8,
   parameter int DRAM_CNT = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 boot_int_rom,
   input  logic                 cfg_we,
   input  logic [CFG_SEL_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0]    cfg_wdata,
   output logic [N_AREA-1:0]    dir_q,
   output logic                 ram_en_q,
   output logic [DRAM_CNT-1:0]  dram_q
);
   localparam logic [N_AREA-1:0] DIR_EXT_BOOT = N_AREA'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q    <= boot_int_rom ? '0 : DIR_EXT_BOOT;
         ram_en_q <= 1'b1;
         dram_q   <= '0;
      end else if (cfg_we) begin
         case (cfg_sel_e'(cfg_addr))
            SEL_DIR:   dir_q    <= cfg_wdata[N_AREA-1:0];
            SEL_RAMEN: ram_en_q <= cfg_wdata[0];
            SEL_DRAM:  dram_q   <= cfg_wdata[DRAM_CNT-1:0];
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/area_cs_decode.sv
`timescale 1ns/1ps
module area_cs_decode #(
   parameter int               ADDR_W      = 24,
   parameter int               AREA_BITS   = 3,
   parameter bit               RAM_PRESENT = 1'b1,
   parameter logic [ADDR_W-1:0] RAM_LO     = 24'hFFB000,
   parameter logic [ADDR_W-1:0] RAM_HI     = 24'hFFEFFF,
   parameter logic [ADDR_W-1:0] REG_LO     = 24'hFFFF00,
   parameter logic [ADDR_W-1:0] REG_HI     = 24'hFFFFFF
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 ram_en,
   output logic [AREA_BITS-1:0] area_idx,
   output logic                 ext_hit
);
   logic in_reg;
   logic ram_internal;

   assign area_idx = addr[ADDR_W-1 -: AREA_BITS];
   assign in_reg   = (addr >= REG_LO) && (addr <= REG_HI);

   generate
      if (RAM_PRESENT) begin : g_ram
         logic in_ram;
         assign in_ram       = (addr >= RAM_LO) && (addr <= RAM_HI);
         assign ram_internal = in_ram && ram_en;
      end else begin : g_no_ram
         logic unused_ram_en;
         assign unused_ram_en = ram_en;
         assign ram_internal  = 1'b0;
      end
   endgenerate

   assign ext_hit = !(in_reg || ram_internal);
endmodule

// File: rtl/area_cs_strobe.sv
`timescale 1ns/1ps
module area_cs_strobe #(
   parameter int N_AREA     = 8,
   parameter int AREA_BITS  = 3,
   parameter int DRAM_FIRST = 2,
   parameter int DRAM_CNT   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_valid,
   input  logic [AREA_BITS-1:0] area_idx,
   input  logic                 ext_hit,
   input  logic [N_AREA-1:0]    dir_q,
   input  logic [DRAM_CNT-1:0]  dram_q,
   output logic [N_AREA-1:0]    cs_n,
   output logic [N_AREA-1:0]    cs_oe,
   output logic [N_AREA-1:0]    ras_mode
);
   logic sel_any;
   assign sel_any = acc_valid && ext_hit;
   assign cs_oe   = dir_q;

   generate
      for (genvar k = 0; k < N_AREA; k++) begin : g_area
         always_ff @(posedge clk) begin
            if (!rst_n) cs_n[k] <= 1'b1;
            else        cs_n[k] <= !(sel_any && (area_idx == AREA_BITS'(k)));
         end

         if ((k >= DRAM_FIRST) && (k < DRAM_FIRST + DRAM_CNT)) begin : g_dram
            assign ras_mode[k] = dram_q[k-DRAM_FIRST];
         end else begin : g_plain
            assign ras_mode[k] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/area_cs_gen.sv
`timescale 1ns/1ps
module area_cs_gen
   import area_cs_pkg::*;
#(
   parameter int                ADDR_W      = 24,
   parameter int                AREA_BITS   = 3,
   parameter int                DATA_W      = 8,
   parameter int                DRAM_FIRST  = 2,
   parameter int                DRAM_CNT    = 4,
   parameter bit                RAM_PRESENT = 1'b1,
   parameter logic [ADDR_W-1:0] RAM_LO      = 24'hFFB000,
   parameter logic [ADDR_W-1:0] RAM_HI      = 24'hFFEFFF,
   parameter logic [ADDR_W-1:0] REG_LO      = 24'hFFFF00,
   parameter logic [ADDR_W-1:0] REG_HI      = 24'hFFFFFF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 boot_int_rom,
   input  logic                 acc_valid,
   input  logic [ADDR_W-1:0]    acc_addr,
   input  logic                 cfg_we,
   input  logic [CFG_SEL_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0]    cfg_wdata,
   output logic [(1<<AREA_BITS)-1:0] cs_n,
   output logic [(1<<AREA_BITS)-1:0] cs_oe,
   output logic [(1<<AREA_BITS)-1:0] ras_mode
);
   localparam int N_AREA = 1 << AREA_BITS;
   localparam logic [AREA_BITS-1:0] TOP_AREA = {AREA_BITS{1'b1}};

   initial begin
      assert (DATA_W == N_AREA) else $error("DATA_W must equal the area count");
      assert (DRAM_CNT >= 1 && DRAM_CNT <= DATA_W) else $error("DRAM_CNT out of range");
      assert (DRAM_FIRST + DRAM_CNT <= N_AREA) else $error("DRAM areas exceed area count");
      assert (REG_LO <= REG_HI) else $error("register window reversed");
      assert (REG_LO[ADDR_W-1 -: AREA_BITS] == TOP_AREA) else $error("register window outside top area");
      if (RAM_PRESENT) begin
         assert (RAM_LO <= RAM_HI) else $error("RAM window reversed");
         assert (RAM_LO[ADDR_W-1 -: AREA_BITS] == TOP_AREA) else $error("RAM window outside top area");
         assert (RAM_HI < REG_LO || REG_HI < RAM_LO) else $error("windows overlap");
      end
   end

   logic [N_AREA-1:0]    dir_q;
   logic                 ram_en_q;
   logic [DRAM_CNT-1:0]  dram_q;
   logic [AREA_BITS-1:0] area_idx;
   logic                 ext_hit;

   area_cs_regs #(
      .N_AREA(N_AREA), .DATA_W(DATA_W), .DRAM_CNT(DRAM_CNT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .boot_int_rom(boot_int_rom),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .dir_q(dir_q), .ram_en_q(ram_en_q), .dram_q(dram_q)
   );

   area_cs_decode #(
      .ADDR_W(ADDR_W), .AREA_BITS(AREA_BITS), .RAM_PRESENT(RAM_PRESENT),
      .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .REG_LO(REG_LO), .REG_HI(REG_HI)
   ) u_decode (
      .addr(acc_addr), .ram_en(ram_en_q), .area_idx(area_idx), .ext_hit(ext_hit)
   );

   area_cs_strobe #(
      .N_AREA(N_AREA), .AREA_BITS(AREA_BITS),
      .DRAM_FIRST(DRAM_FIRST), .DRAM_CNT(DRAM_CNT)
   ) u_strobe (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .area_idx(area_idx),
      .ext_hit(ext_hit), .dir_q(dir_q), .dram_q(dram_q),
      .cs_n(cs_n), .cs_oe(cs_oe), .ras_mode(ras_mode)
   );
endmodule

// File: rtl/area_cs_chk.sv
`timescale 1ns/1ps
module area_cs_chk #(
   parameter int                ADDR_W      = 24,
   parameter int                AREA_BITS   = 3,
   parameter int                DATA_W      = 8,
   parameter int                DRAM_FIRST  = 2,
   parameter int                DRAM_CNT    = 4,
   parameter bit                RAM_PRESENT = 1'b1,
   parameter logic [ADDR_W-1:0] RAM_LO      = 24'hFFB000,
   parameter logic [ADDR_W-1:0] RAM_HI      = 24'hFFEFFF,
   parameter logic [ADDR_W-1:0] REG_LO      = 24'hFFFF00,
   parameter logic [ADDR_W-1:0] REG_HI      = 24'hFFFFFF
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      acc_valid,
   input logic [ADDR_W-1:0]         acc_addr,
   input logic                      cfg_we,
   input logic [1:0]                cfg_addr,
   input logic [DATA_W-1:0]         cfg_wdata,
   input logic                      ram_en,
   input logic [(1<<AREA_BITS)-1:0] cs_n,
   input logic [(1<<AREA_BITS)-1:0] cs_oe,
   input logic [(1<<AREA_BITS)-1:0] ras_mode
);
   localparam int N_AREA = 1 << AREA_BITS;
   logic [AREA_BITS-1:0] a_idx;
   logic                 in_reg;
   logic                 in_ram;

   assign a_idx  = acc_addr[ADDR_W-1 -: AREA_BITS];
   assign in_reg = (acc_addr >= REG_LO) && (acc_addr <= REG_HI);
   assign in_ram = RAM_PRESENT && (acc_addr >= RAM_LO) && (acc_addr <= RAM_HI);

   a_r1_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   a_r2_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (&cs_n));

   a_r2_area_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && a_idx != {AREA_BITS{1'b1}}) |=> !cs_n[$past(a_idx)]);

   a_r3_reg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && in_reg) |=> (&cs_n));

   a_r4_ram_internal: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && in_ram && ram_en) |=> (&cs_n));

   a_r4_ram_external: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && in_ram && !ram_en) |=> !cs_n[N_AREA-1]);

   a_r5_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 2'd0) |=> (cs_oe == $past(cfg_wdata[N_AREA-1:0])));

   a_r7_dram_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 2'd2) |=>
         (ras_mode[DRAM_FIRST +: DRAM_CNT] == $past(cfg_wdata[DRAM_CNT-1:0])));

   a_r8_dead_select: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 2'd3) |=> ($stable(cs_oe) && $stable(ras_mode) && $stable(ram_en)));
endmodule

bind area_cs_gen area_cs_chk #(
   .ADDR_W(ADDR_W), .AREA_BITS(AREA_BITS), .DATA_W(DATA_W),
   .DRAM_FIRST(DRAM_FIRST), .DRAM_CNT(DRAM_CNT), .RAM_PRESENT(RAM_PRESENT),
   .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .REG_LO(REG_LO), .REG_HI(REG_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
   .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
   .ram_en(ram_en_q), .cs_n(cs_n), .cs_oe(cs_oe), .ras_mode(ras_mode)
);

// File: tb/area_cs_gen_tb.sv
`timescale 1ns/1ps
module area_cs_gen_tb;
   localparam logic [23:0] RAM_LO = 24'hFFB000;
   localparam logic [23:0] RAM_HI = 24'hFFEFFF;
   localparam logic [23:0] REG_LO = 24'hFFFF00;
   localparam logic [23:0] REG_HI = 24'hFFFFFF;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       boot_int_rom = 1'b0;
   logic       acc_valid = 1'b0;
   logic [23:0] acc_addr = '0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cs_n, cs_oe, ras_mode;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [7:0] m_dir;
   logic       m_ram_en;
   logic [3:0] m_dram;

   always #2 clk = ~clk;

   area_cs_gen #(
      .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .REG_LO(REG_LO), .REG_HI(REG_HI)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .boot_int_rom(boot_int_rom),
      .acc_valid(acc_valid), .acc_addr(acc_addr),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cs_n(cs_n), .cs_oe(cs_oe), .ras_mode(ras_mode)
   );

   function automatic logic [7:0] exp_cs(bit v, logic [23:0] a, bit re);
      logic [7:0] r = 8'hFF;
      bit internal = (a >= REG_LO && a <= REG_HI) || (re && a >= RAM_LO && a <= RAM_HI);
      if (v && !internal) r[a[23:21]] = 1'b0;
      return r;
   endfunction

   function automatic string cs_tag(logic [23:0] a);
      if (a >= REG_LO && a <= REG_HI) return "R3";
      if (a[23:21] == 3'd7) return "R4";
      return "R2";
   endfunction

   task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic check_cfg(string tag_oe, string tag_ras);
      chk(cs_oe == m_dir, tag_oe, cs_oe, m_dir);
      chk(ras_mode == {2'b00, m_dram, 2'b00}, tag_ras, ras_mode, {2'b00, m_dram, 2'b00});
   endtask

   // Called at a falling edge; drives one cycle and checks at the next falling edge.
   task automatic step(bit v, logic [23:0] a, bit we, logic [1:0] ca, logic [7:0] wd);
      logic [7:0] e;
      acc_valid = v; acc_addr = a; cfg_we = we; cfg_addr = ca; cfg_wdata = wd;
      e = exp_cs(v, a, m_ram_en);
      if (we) begin
         case (ca)
            2'd0: m_dir = wd;
            2'd1: m_ram_en = wd[0];
            2'd2: m_dram = wd[3:0];
            default: ;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      chk(cs_n == e, v ? cs_tag(a) : "R2", cs_n, e);
      chk($countones(~cs_n) <= 1, "R1", cs_n, e);
      check_cfg("R5", "R7");
   endtask

   task automatic do_reset(bit rom);
      boot_int_rom = rom; rst_n = 1'b0;
      acc_valid = 1'b0; cfg_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_dir = rom ? 8'h00 : 8'h01; m_ram_en = 1'b1; m_dram = 4'h0;
      chk(cs_n == 8'hFF, "R6", cs_n, 8'hFF);
      check_cfg("R6", "R6");
   endtask

   function automatic logic [23:0] rand_addr();
      logic [23:0] edges [6];
      edges = '{RAM_LO - 24'd1, RAM_LO, RAM_HI, RAM_HI + 24'd1, REG_LO - 24'd1, REG_LO};
      case ($urandom % 8)
         0, 1, 2, 3: return 24'($urandom);
         4: return RAM_LO + 24'($urandom % (RAM_HI - RAM_LO + 1));
         5: return REG_LO + 24'($urandom % (REG_HI - REG_LO + 1));
         6: return edges[$urandom % 6];
         default: return {3'($urandom), 21'd0} - 24'($urandom % 2);
      endcase
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset(1'b0);                              // R6 external boot: area 0 pin output

      step(1, 24'h000010, 0, 0, 0);                // R2 area 0
      step(0, 24'h000010, 0, 0, 0);                // R2 release
      step(1, 24'h6ABCDE, 0, 0, 0);                // R2 multi-cycle access, area 3
      step(1, 24'h6ABCDE, 0, 0, 0);
      step(1, 24'h6ABCDF, 0, 0, 0);
      step(1, 24'h3FFFFF, 0, 0, 0);                // back-to-back, area 1 top
      step(1, 24'hC00000, 0, 0, 0);                // area 6 bottom
      step(0, 24'h0, 0, 0, 0);
      step(1, REG_LO, 0, 0, 0);                    // R3
      step(1, REG_HI, 0, 0, 0);                    // R3
      step(1, REG_LO - 24'd1, 0, 0, 0);            // R4 gap between windows
      step(1, RAM_LO, 0, 0, 0);                    // R4 internal RAM
      step(1, RAM_LO - 24'd1, 0, 0, 0);            // R4 external just below
      step(0, 24'h0, 1, 2'd1, 8'h00);              // R7 RAM enable off
      step(1, RAM_HI, 0, 0, 0);                    // R4 RAM now external
      step(1, RAM_LO, 1, 2'd1, 8'h01);             // write and access same cycle
      step(1, RAM_LO, 0, 0, 0);                    // R4 internal again
      step(0, 24'h0, 1, 2'd0, 8'hA5);              // R5 direction bits
      step(0, 24'h0, 1, 2'd2, 8'hFF);              // R7 all DRAM areas
      step(0, 24'h0, 1, 2'd2, 8'h05);              // R7 areas 2 and 4
      step(0, 24'h0, 1, 2'd3, 8'h5A);              // R8 dead select
      step(1, RAM_LO, 1, 2'd3, 8'h00);             // R8 RAM enable untouched

      for (int i = 0; i < 1500; i++) begin
         bit we = ($urandom % 10) == 0;
         step(1'($urandom % 4 != 0), rand_addr(), we, 2'($urandom), 8'($urandom));
      end

      do_reset(1'b1);                              // R6 internal ROM boot: all inputs
      step(1, 24'h000000, 0, 0, 0);
      for (int i = 0; i < 200; i++) begin
         bit we = ($urandom % 8) == 0;
         step(1'($urandom % 2), rand_addr(), we, 2'($urandom), 8'($urandom));
      end
      do_reset(1'b0);                              // R6 again after traffic

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule